// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

This is a single-clock FIFO of parameterised depth and width. While reset is held, a mode input is captured. In standard mode the two status pins report full and empty. In first-word-fall-through mode the same pins report input-ready and output-ready. In that mode the head word moves into the output register without a read request, and that register counts as one more storage slot.

The read side has a registered chip-select that decides whether the data output is driven. An asynchronous output enable also gates the drive. The drive state is a separate output, and undriven data reads as zero. Reads need both read enable and chip-select low. Writes need both write enable and write chip-select low.

A one-cycle mark pulse saves the read position and turns on retransmit mode. A later rewind, taken only while read chip-select is low, returns the reader to that position. From the mark onward, the full flag measures the writer against the saved position.

Top module: `dm_fifo`

## Requirements
- R1: In standard mode `wr_stat` is 1 after reset and goes to 0 after the edge of the DEPTH-th write with no read. While it is 0, writes change nothing. One read makes it 1 again.
- R2: In fall-through mode `wr_stat` is 0 while space exists. It goes to 1 only after DEPTH+1 writes with no read (the first word having fallen into the output register). Writes made while it is 1 are dropped.
- R3: In standard mode `rd_stat` is 0 when empty. It rises at the second clock edge after the edge that writes into an empty FIFO. A read (rd_n and rcs_n low while `rd_stat` is 1) puts the word on `rdata` at that edge. Reads while `rd_stat` is 0 leave `rdata` and the queue unchanged.
- R4: In fall-through mode `rd_stat` falls at the third edge after the write into an empty FIFO, the same edge at which the word is loaded into the output register.
- R5: In fall-through mode `rd_stat` rises only on a true read of the last held word. That word stays on `rdata`, and further reads change nothing until `rd_stat` falls again.
- R6: `rcs_n` has no effect on the status pins or on the fall-through of the first word.
- R7: `rdata_drv` equals the inverse of `rcs_n` sampled at the previous edge, ANDed with the inverse of `oe_n`, which acts at once. `rdata` is zero whenever `rdata_drv` is 0.
- R8: While `rst_n` is low, `rdata_drv` equals the inverse of `oe_n` whatever `rcs_n` is. The mode is taken from `fwft_sel` during reset only. After reset the status pins are standard 1/0 (`wr_stat`/`rd_stat`) and fall-through 0/1.
- R9: A `mark` pulse saves the read position. A `rewind` at an edge with `rcs_n` low reloads it: `rd_stat` goes to its empty value and the saved words are read again in order. A `rewind` with `rcs_n` high is ignored.
- R10: After a mark, the full indication is reached when the writes since the marked position total DEPTH, even if those words have been read.
- R11: A write with `wcs_n` high stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwft_sel | input | 1 | Mode captured in reset: 1 fall-through, 0 standard |
| wr_n | input | 1 | Write enable, active low |
| wcs_n | input | 1 | Write chip-select, active low |
| wdata | input | W | Write data |
| rd_n | input | 1 | Read enable, active low |
| rcs_n | input | 1 | Read chip-select, registered, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mark | input | 1 | Save current read position |
| rewind | input | 1 | Return read position to the mark |
| rdata | output | W | Read data, zero when not driven |
| rdata_drv | output | 1 | 1 when the data output is driven |
| wr_stat | output | 1 | Full flag (active low) or input-ready (active low) |
| rd_stat | output | 1 | Empty flag (active low) or output-ready (active low) |

## Verification
The full and input-ready indications are checked at the first falling edge after the write edge that fills the store. Standard read data and the emptying of the flag are checked one edge after the read request. The standard empty flag is sampled after each of the two edges that follow a write into an empty store, and the output-ready indication after each of the three. The drive output is checked before and after the edge that samples chip-select, and again right after the output-enable change, with no edge in between. A queue of accepted writes is popped by a monitor at the falling edge where each word is due.

// File: rtl/dm_fifo_pkg.sv
package dm_fifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dm_fifo_ram.sv
module dm_fifo_ram #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dm_fifo_drv.sv
module dm_fifo_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic rcs_n,
    input  logic oe_n,
    output logic drv
);
    logic drv_d, drv_q;

    // In reset only the enable can release the bus; afterwards the select rules.
    always_comb drv_d = rst_n ? !rcs_n : 1'b1;

    always_ff @(posedge clk) drv_q <= drv_d;

    assign drv = drv_q && !oe_n;
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo
    import dm_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fwft_sel,
    input  logic         wr_n,
    input  logic         wcs_n,
    input  logic [W-1:0] wdata,
    input  logic         rd_n,
    input  logic         rcs_n,
    input  logic         oe_n,
    input  logic         mark,
    input  logic         rewind,
    output logic [W-1:0] rdata,
    output logic         rdata_drv,
    output logic         wr_stat,
    output logic         rd_stat
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [PW-1:0] mptr;
        logic          rt_mode;
        fifo_mode_e    mode;
        logic          s1;      // first stage of the not-empty pipe
        logic          s2;      // second stage: standard empty flag
        logic          full;
        logic          ovalid;  // output register holds a word
        logic [W-1:0]  dout;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0]  ram_rd;
    logic [PW-1:0] occ_q, occ_d;
    logic          wr_ok, rd_req, take, load, pop, rt_go, is_fwft;

    dm_fifo_ram #(.W(W), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (st_q.wptr[AW-1:0]),
        .wdata (wdata),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (ram_rd)
    );

    dm_fifo_drv u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .rcs_n (rcs_n),
        .oe_n  (oe_n),
        .drv   (rdata_drv)
    );

    always_comb begin
        st_d    = st_q;
        is_fwft = (st_q.mode == MODE_FWFT);
        occ_q   = st_q.wptr - st_q.rptr;
        wr_ok   = !wr_n && !wcs_n && !st_q.full;
        rd_req  = !rd_n && !rcs_n;
        rt_go   = rewind && !rcs_n && st_q.rt_mode;
        take    = 1'b0;
        load    = 1'b0;
        if (is_fwft) begin
            take = rd_req && st_q.ovalid;
            load = st_q.s2 && (!st_q.ovalid || take);
            pop  = load;
        end else begin
            pop  = rd_req && st_q.s2;
        end

        if (wr_ok) st_d.wptr = st_q.wptr + 1'b1;

        if (mark && !rt_go) begin
            st_d.mptr    = st_q.rptr;
            st_d.rt_mode = 1'b1;
        end

        if (rt_go) begin
            st_d.rptr = st_q.mptr;
            if (is_fwft) st_d.ovalid = 1'b0;
        end else begin
            if (pop) begin
                st_d.rptr = st_q.rptr + 1'b1;
                st_d.dout = ram_rd;
            end
            if (is_fwft) begin
                if (load)      st_d.ovalid = 1'b1;
                else if (take) st_d.ovalid = 1'b0;
            end
        end

        occ_d     = st_d.wptr - st_d.rptr;
        st_d.s1   = !rt_go && (occ_q != '0) && (occ_d != '0);
        st_d.s2   = !rt_go && st_q.s1 && (occ_d != '0);
        st_d.full = st_d.rt_mode ? ((st_d.wptr - st_d.mptr) == FULL_CNT)
                                 : (occ_d == FULL_CNT);

        if (!rst_n) begin
            st_d      = '0;
            st_d.mode = fifo_mode_e'(fwft_sel);
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign wr_stat = (st_q.mode == MODE_FWFT) ? st_q.full    : !st_q.full;
    assign rd_stat = (st_q.mode == MODE_FWFT) ? !st_q.ovalid : st_q.s2;
    assign rdata   = rdata_drv ? st_q.dout : '0;
endmodule

// File: rtl/dm_fifo_chk.sv
module dm_fifo_chk #(
    parameter int PW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fwft,
    input logic          wr_n,
    input logic          wcs_n,
    input logic          rcs_n,
    input logic          oe_n,
    input logic          rewind,
    input logic          wr_stat,
    input logic          rd_stat,
    input logic          rdata_drv,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);
    localparam logic [PW-1:0] LIM = PW'(DEPTH);

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= LIM);

    p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !wr_stat && !wr_n && !wcs_n) |=> $stable(wptr));

    p_ir_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && wr_stat && !wr_n) |=> $stable(wptr));

    p_empty_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !rd_stat && !rewind) |=> $stable(rptr));

    p_drive_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && $past(rst_n)) |-> (rdata_drv == !$past(rcs_n)));

    p_wcs_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wcs_n |=> $stable(wptr));
endmodule

bind dm_fifo dm_fifo_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwft      (st_q.mode),
    .wr_n      (wr_n),
    .wcs_n     (wcs_n),
    .rcs_n     (rcs_n),
    .oe_n      (oe_n),
    .rewind    (rewind),
    .wr_stat   (wr_stat),
    .rd_stat   (rd_stat),
    .rdata_drv (rdata_drv),
    .wptr      (st_q.wptr),
    .rptr      (st_q.rptr)
);

// File: tb/dm_fifo_tb.sv
module dm_fifo_tb;
    localparam int DEPTH = 8;
    localparam int W     = 8;

    logic clk = 1'b0, rst_n = 1'b0, fwft_sel = 1'b0;
    logic wr_n = 1'b1, wcs_n = 1'b0, rd_n = 1'b1, rcs_n = 1'b1, oe_n = 1'b0;
    logic mark = 1'b0, rewind = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rdata_drv, wr_stat, rd_stat;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [W-1:0] sb[$];
    string mon_tag;
    event rd_evt;

    always #10 clk = ~clk;

    dm_fifo #(.DEPTH(DEPTH), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_n(wr_n), .wcs_n(wcs_n),
        .wdata(wdata), .rd_n(rd_n), .rcs_n(rcs_n), .oe_n(oe_n), .mark(mark),
        .rewind(rewind), .rdata(rdata), .rdata_drv(rdata_drv),
        .wr_stat(wr_stat), .rd_stat(rd_stat)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the driver says a word is due.
    always begin
        @(rd_evt);
        if (sb.size() == 0) chk_eq({mon_tag, " scoreboard empty"}, 1, 0);
        else chk_eq(mon_tag, int'(rdata), int'(sb.pop_front()));
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0; fwft_sel = m; wr_n = 1'b1; rd_n = 1'b1; rcs_n = 1'b1;
        wcs_n = 1'b0; oe_n = 1'b0; mark = 1'b0; rewind = 1'b0;
        sb.delete();
        repeat (3) tick();
        chk_eq("R8 driven in reset despite rcs_n high", rdata_drv, 1);
        oe_n = 1'b1; #1;
        chk_eq("R8 oe_n releases in reset", rdata_drv, 0);
        oe_n = 1'b0;
        rst_n = 1'b1;
        fwft_sel = !m;
        tick();
        chk_eq("R8 wr_stat after reset", wr_stat, m ? 0 : 1);
        chk_eq("R8 rd_stat after reset", rd_stat, m ? 1 : 0);
        chk_eq("R8 first edge applies rcs_n", rdata_drv, 0);
    endtask

    task automatic push(input logic [W-1:0] d, input bit acc);
        wdata = d; wr_n = 1'b0;
        tick();
        wr_n = 1'b1;
        if (acc) sb.push_back(d);
    endtask

    task automatic std_read(input string tag);
        rcs_n = 1'b0; rd_n = 1'b0;
        tick();
        rd_n = 1'b1;
        mon_tag = tag;
        -> rd_evt;
        #1;
    endtask

    task automatic fwft_read(input string tag);
        chk_eq({tag, " output-ready before read"}, rd_stat, 0);
        mon_tag = tag;
        -> rd_evt;
        #1;
        rd_n = 1'b0;
        tick();
        rd_n = 1'b1;
    endtask

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        push(8'hA1, 1'b1);
        chk_eq("R3 empty after write edge", rd_stat, 0);
        tick();
        chk_eq("R3 empty one edge later", rd_stat, 0);
        tick();
        chk_eq("R3 not-empty second edge", rd_stat, 1);

        rcs_n = 1'b0; #1;
        chk_eq("R7 drive waits for edge", rdata_drv, 0);
        tick();
        chk_eq("R7 driven after edge", rdata_drv, 1);
        oe_n = 1'b1; #1;
        chk_eq("R7 oe_n releases at once", rdata_drv, 0);
        chk_eq("R7 undriven data zero", int'(rdata), 0);
        oe_n = 1'b0; #1;

        std_read("R3 read data");
        chk_eq("R3 empty after last read", rd_stat, 0);
        rd_n = 1'b0; tick(); rd_n = 1'b1;
        chk_eq("R3 read while empty holds data", int'(rdata), 8'hA1);

        wcs_n = 1'b1;
        push(8'hC3, 1'b0);
        wcs_n = 1'b0;
        repeat (3) tick();
        chk_eq("R11 deselected write stores nothing", rd_stat, 0);

        for (int i = 0; i < DEPTH; i++) begin
            push(W'(8'h10 + i), 1'b1);
            if (i == DEPTH - 2) chk_eq("R1 not full one short", wr_stat, 1);
        end
        chk_eq("R1 full after DEPTH writes", wr_stat, 0);
        push(8'hEE, 1'b0);
        chk_eq("R1 still full after ignored write", wr_stat, 0);
        std_read("R1 drain");
        chk_eq("R1 space after one read", wr_stat, 1);
        for (int i = 1; i < DEPTH; i++) std_read("R1 drain");
        chk_eq("R1 empty after drain", rd_stat, 0);

        for (int i = 0; i < 4; i++) push(W'(8'h40 + i), 1'b1);
        repeat (3) tick();
        mark = 1'b1; tick(); mark = 1'b0;
        std_read("R9 before rewind");
        std_read("R9 before rewind");
        rewind = 1'b1; rcs_n = 1'b1; tick(); rewind = 1'b0;
        std_read("R9 rewind ignored while deselected");
        rewind = 1'b1; tick(); rewind = 1'b0;
        chk_eq("R9 flag empty after rewind", rd_stat, 0);
        sb.delete();
        for (int i = 0; i < 4; i++) sb.push_back(W'(8'h40 + i));
        repeat (3) tick();
        for (int i = 0; i < 4; i++) std_read("R9 replay from mark");
        for (int i = 0; i < DEPTH - 4; i++) push(W'(8'h50 + i), 1'b0);
        chk_eq("R10 full measured from mark", wr_stat, 0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        push(8'hB1, 1'b1);
        chk_eq("R4 not ready at write edge", rd_stat, 1);
        tick();
        chk_eq("R4 not ready edge 1", rd_stat, 1);
        tick();
        chk_eq("R4 not ready edge 2", rd_stat, 1);
        tick();
        chk_eq("R4 R6 ready at edge 3 with rcs_n high", rd_stat, 0);
        chk_eq("R7 undriven while deselected", rdata_drv, 0);
        chk_eq("R7 undriven data zero", int'(rdata), 0);
        rcs_n = 1'b0;
        tick();
        chk_eq("R7 driven after select", rdata_drv, 1);
        fwft_read("R4 R6 first word fell through");
        chk_eq("R5 ready high after last read", rd_stat, 1);
        chk_eq("R5 last word held", int'(rdata), 8'hB1);
        rd_n = 1'b0; tick(); rd_n = 1'b1;
        chk_eq("R5 extra read holds word", int'(rdata), 8'hB1);
        chk_eq("R5 extra read keeps flag", rd_stat, 1);

        push(8'h60, 1'b1);
        repeat (3) tick();
        for (int i = 0; i < DEPTH; i++) begin
            push(W'(8'h70 + i), 1'b1);
            if (i == DEPTH - 2) chk_eq("R2 space one short", wr_stat, 0);
        end
        chk_eq("R2 no space after DEPTH+1", wr_stat, 1);
        push(8'hEF, 1'b0);
        for (int i = 0; i < DEPTH + 1; i++) fwft_read("R2 drain");
        chk_eq("R5 empty after drain", rd_stat, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule